// File: doc/BRIEF.md
# Fault Auto-Restart Sequencer

This block decides when a resonant half-bridge converter may switch. It watches the main supply good flag, the high-side supply good flag, the input-line comparators, an overcurrent fault pulse, a remote-off request and an over-temperature flag. From these it drives two outputs. One enables the pull-up that discharges the soft-start capacitor. The other lets the power stage run.

After a fault the discharge is held for a timed interval before the next start attempt. The interval is counted in ticks of the maximum-frequency oscillator. There are two interval lengths. The short one applies to the first start after the main supply comes up, and it also covers a line that reaches brown-in for the first time. The long one applies to every other fault. Over-temperature latches the sequencer off. The latch clears only after the high-side supply has dropped and returned and the over-temperature flag has gone low.

Top module: `fault_restart_seq`

## Requirements
- R1: Out of reset, and whenever the sequencer is not running, `discharge_o`=1 and `run_o`=0. In the running state `discharge_o`=0 and `run_o`=1. `run_o` only ever rises from a cycle in which `discharge_o` was 1.
- R2: The first start after reset, or after a main supply loss, waits `SHORT_WAIT` ticks. This still applies when the line first reaches brown-in some time after the supply came up.
- R3: An `oc_fault_i` pulse while running drops `run_o` at the next clock edge. A restart then needs `LONG_WAIT` ticks.
- R4: `remote_off_i` acts like a fault. It drops `run_o` at the next edge, and a restart needs `LONG_WAIT` ticks.
- R5: Timing of the wait count:
  - The count is cleared at every clock edge where the sequencer is not in the discharge state, and at every edge where any fault is present.
  - A fault is `oc_fault_i`, `remote_off_i`, a line that is not good, or `vcch_ok_i`=0.
  - Otherwise the count advances by one at each edge where `tick_i`=1.
  - `run_o` rises at the first edge at which the count equals the wait length and no fault is present.
  - A fault during the wait therefore restarts the wait.
- R6: When `vcc_ok_i`=0, the sequencer goes idle at the next edge with `run_o`=0, and the next start uses the short wait.
- R7: The wait count advances only on edges where `tick_i`=1.
- R8: Over-temperature latching:
  - `otp_i`=1 latches the sequencer off at the next edge.
  - It leaves the latch only when `vcch_ok_i` has been 0 at some edge during the latch, `vcch_ok_i` is back at 1, and `otp_i`=0.
  - On leaving, it enters the discharge state and uses the long wait.
- R9: `vcch_ok_i`=0 is a fault. It stops running at the next edge, and a restart needs `LONG_WAIT` ticks after it returns.
- R10: Line hysteresis. `line_low_i`=1 (below brown-out) marks the line bad. `line_in_i`=1 (above brown-in) marks it good. When both are 0 the previous state is kept. The line state is registered, so it takes effect one edge after the input changes.
- R11: Overvoltage hysteresis. `ov_hi_i`=1 (above the upper level) blocks the line. The block holds until `ov_lo_i`=0 (below the lower restart level). The block is also registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| tick_i | input | 1 | one-cycle strobe at the max-frequency oscillator rate |
| vcc_ok_i | input | 1 | main supply above its UVLO level |
| vcch_ok_i | input | 1 | high-side supply above its UVLO level |
| line_in_i | input | 1 | input line above brown-in |
| line_low_i | input | 1 | input line below brown-out |
| ov_hi_i | input | 1 | input line above the upper overvoltage level |
| ov_lo_i | input | 1 | input line above the lower overvoltage restart level |
| oc_fault_i | input | 1 | overcurrent fault pulse |
| remote_off_i | input | 1 | remote shutdown request |
| otp_i | input | 1 | over-temperature flag |
| discharge_o | output | 1 | soft-start discharge pull-up enable |
| run_o | output | 1 | power stage allowed to switch |

## Verification
The state that can go wrong inside this block is small: the first-start flag, the wait count, the two line hysteresis bits and the over-temperature cycle flag. Each of them shows up at the ports only as the time `run_o` takes to return. The bench therefore measures the exact number of edges from the moment a cause is removed to the rise of `run_o`, and compares it with the count derived from R5. A first-start flag in the wrong state gives a restart that is `LONG_WAIT - SHORT_WAIT` ticks early or late. A count that is not restarted by a fault gives a restart that is too early. A lost hysteresis bit or cycle flag lets `run_o` rise within one wait length when it must stay low.

// File: rtl/frs_pkg.sv
package frs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DISCH = 2'd1,
    ST_RUN   = 2'd2,
    ST_OTP   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/frs_line_mon.sv
module frs_line_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_in_i,
  input  logic line_low_i,
  input  logic ov_hi_i,
  input  logic ov_lo_i,
  output logic line_good_o
);
  logic brown_ok_q, ov_blk_q;

  // brown-in / brown-out hysteresis
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         brown_ok_q <= 1'b0;
    else if (line_low_i) brown_ok_q <= 1'b0;
    else if (line_in_i)  brown_ok_q <= 1'b1;
  end

  // overvoltage hysteresis: block until below the lower level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ov_blk_q <= 1'b0;
    else if (ov_hi_i)  ov_blk_q <= 1'b1;
    else if (!ov_lo_i) ov_blk_q <= 1'b0;
  end

  assign line_good_o = brown_ok_q & ~ov_blk_q;
endmodule

// File: rtl/frs_wait_timer.sv
module frs_wait_timer #(
  parameter int unsigned SHORT_WAIT = 1024,
  parameter int unsigned LONG_WAIT  = 131072
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  logic short_i,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(LONG_WAIT + 1);
  localparam logic [CNT_W-1:0] LIM_S = CNT_W'(SHORT_WAIT);
  localparam logic [CNT_W-1:0] LIM_L = CNT_W'(LONG_WAIT);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim    = short_i ? LIM_S : LIM_L;
  assign done_o = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (tick_i && !done_o)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/frs_seq_fsm.sv
module frs_seq_fsm
  import frs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vcc_ok_i,
  input  logic vcch_ok_i,
  input  logic fault_i,
  input  logic otp_i,
  input  logic done_i,
  output logic cnt_clr_o,
  output logic short_o,
  output logic discharge_o,
  output logic run_o
);
  seq_state_e state_q, state_d;
  logic first_q, cyc_seen_q;

  always_comb begin
    state_d = state_q;
    if (state_q != ST_OTP && otp_i) begin
      state_d = ST_OTP;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (vcc_ok_i) state_d = ST_DISCH;
        ST_DISCH: if (!vcc_ok_i) state_d = ST_IDLE;
                  else if (!fault_i && done_i) state_d = ST_RUN;
        ST_RUN:   if (!vcc_ok_i) state_d = ST_IDLE;
                  else if (fault_i) state_d = ST_DISCH;
        ST_OTP:   if (cyc_seen_q && vcch_ok_i && !otp_i) state_d = ST_DISCH;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      first_q    <= 1'b1;
      cyc_seen_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q != ST_OTP && !vcc_ok_i) first_q <= 1'b1;
      else if (state_d == ST_RUN)         first_q <= 1'b0;
      if (state_q != ST_OTP)  cyc_seen_q <= 1'b0;
      else if (!vcch_ok_i)    cyc_seen_q <= 1'b1;
    end
  end

  assign cnt_clr_o   = (state_q != ST_DISCH) | fault_i;
  assign short_o     = first_q;
  assign run_o       = (state_q == ST_RUN);
  assign discharge_o = ~run_o;
endmodule

// File: rtl/fault_restart_seq.sv
module fault_restart_seq #(
  parameter int unsigned SHORT_WAIT = 1024,
  parameter int unsigned LONG_WAIT  = 131072
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic vcc_ok_i,
  input  logic vcch_ok_i,
  input  logic line_in_i,
  input  logic line_low_i,
  input  logic ov_hi_i,
  input  logic ov_lo_i,
  input  logic oc_fault_i,
  input  logic remote_off_i,
  input  logic otp_i,
  output logic discharge_o,
  output logic run_o
);
  logic line_good, fault, cnt_clr, short_sel, done;

  frs_line_mon u_line (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .line_in_i(line_in_i), .line_low_i(line_low_i),
    .ov_hi_i(ov_hi_i), .ov_lo_i(ov_lo_i),
    .line_good_o(line_good)
  );

  assign fault = oc_fault_i | remote_off_i | ~line_good | ~vcch_ok_i;

  frs_wait_timer #(.SHORT_WAIT(SHORT_WAIT), .LONG_WAIT(LONG_WAIT)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(cnt_clr), .tick_i(tick_i), .short_i(short_sel),
    .done_o(done)
  );

  frs_seq_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .vcc_ok_i(vcc_ok_i), .vcch_ok_i(vcch_ok_i),
    .fault_i(fault), .otp_i(otp_i), .done_i(done),
    .cnt_clr_o(cnt_clr), .short_o(short_sel),
    .discharge_o(discharge_o), .run_o(run_o)
  );
endmodule

// File: rtl/frs_checker.sv
module frs_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic vcc_ok_i,
  input logic vcch_ok_i,
  input logic oc_fault_i,
  input logic remote_off_i,
  input logic otp_i,
  input logic discharge_o,
  input logic run_o
);
  assert_run_from_disch_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> $past(discharge_o));

  assert_oc_stops_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_fault_i |=> (!run_o && discharge_o));

  assert_remote_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remote_off_i |=> !run_o);

  assert_start_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> $past(!oc_fault_i && !remote_off_i && vcc_ok_i && vcch_ok_i));

  assert_uvlo_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vcc_ok_i |=> !run_o);

  assert_otp_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    otp_i |=> !run_o);

  assert_vcch_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vcch_ok_i |=> !run_o);
endmodule

bind fault_restart_seq frs_checker chk_i (.*);

// File: tb/fault_restart_seq_tb_top.sv
`timescale 1ns/1ps
module fault_restart_seq_tb_top;
  localparam int S = 8;
  localparam int L = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b1, vcc_ok = 1'b0, vcch_ok = 1'b1;
  logic line_in = 1'b0, line_low = 1'b0, ov_hi = 1'b0, ov_lo = 1'b0;
  logic oc = 1'b0, roff = 1'b0, otp = 1'b0;
  logic discharge, run;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fault_restart_seq #(.SHORT_WAIT(S), .LONG_WAIT(L)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick),
    .vcc_ok_i(vcc_ok), .vcch_ok_i(vcch_ok),
    .line_in_i(line_in), .line_low_i(line_low), .ov_hi_i(ov_hi), .ov_lo_i(ov_lo),
    .oc_fault_i(oc), .remote_off_i(roff), .otp_i(otp),
    .discharge_o(discharge), .run_o(run)
  );

  // {line_in, line_low, ov_hi, ov_lo, hold[7:0], exp_run}
  localparam int NV = 7;
  localparam logic [12:0] VEC [NV] = '{
    {4'b0000, 8'd4,  1'b1},  // R10 between levels, keeps on
    {4'b0100, 8'd4,  1'b0},  // R10 brown-out
    {4'b0000, 8'd60, 1'b0},  // R10 between levels, stays off
    {4'b1000, 8'd60, 1'b1},  // R10 brown-in, long restart
    {4'b1011, 8'd4,  1'b0},  // R11 above upper OV
    {4'b1001, 8'd60, 1'b0},  // R11 between OV levels, held off
    {4'b1000, 8'd60, 1'b1}   // R11 below lower OV, restart
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_out(input string tag, input logic er);
    check({tag, " run"}, int'(run), int'(er));
    check({tag, " discharge"}, int'(discharge), int'(!er));
  endtask

  // counts edges from the current negedge until run_o is seen high
  task automatic measure(input string tag, input int exp);
    int n = 0;
    while (n < 300) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (run) break;
    end
    check(tag, n, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad);
      $finish;
    end
  end

  initial begin
    idle(2);
    check_out("R1 reset", 1'b0);
    rst_ni = 1'b1;
    idle(2);
    check_out("R1 idle", 1'b0);

    // R2: supply up but line below brown-in; first brown-in still uses short wait
    vcc_ok = 1'b1;
    idle(20);
    check_out("R2 no line", 1'b0);
    line_in = 1'b1;
    measure("R2 first start short wait", S + 2);
    check_out("R1 running", 1'b1);

    // R10 / R11 vector walk
    for (int i = 0; i < NV; i++) begin
      {line_in, line_low, ov_hi, ov_lo} = VEC[i][12:9];
      idle(int'(VEC[i][8:1]));
      check_out($sformatf("R10/R11 vector %0d", i), VEC[i][0]);
    end

    // R3 overcurrent pulse: long wait
    oc = 1'b1; idle(1); oc = 1'b0;
    check_out("R3 oc stop", 1'b0);
    measure("R3 long wait", L + 1);

    // R4 remote-off
    roff = 1'b1; idle(1); roff = 1'b0;
    check_out("R4 remote stop", 1'b0);
    measure("R4 long wait", L + 1);

    // R5 fault during wait restarts the count
    oc = 1'b1; idle(1); oc = 1'b0;
    idle(10);
    check_out("R5 mid wait", 1'b0);
    oc = 1'b1; idle(1); oc = 1'b0;
    measure("R5 count restarted", L + 1);

    // R7 count only on ticks
    tick = 1'b0;
    oc = 1'b1; idle(1); oc = 1'b0;
    idle(50);
    check_out("R7 no tick", 1'b0);
    tick = 1'b1;
    measure("R7 tick count", L + 1);

    // R9 high-side supply low is a fault
    vcch_ok = 1'b0;
    idle(5);
    check_out("R9 vcch low", 1'b0);
    vcch_ok = 1'b1;
    measure("R9 long wait", L + 1);

    // R8 over-temperature latch
    otp = 1'b1; idle(1);
    check_out("R8 otp stop", 1'b0);
    otp = 1'b0;
    idle(60);
    check_out("R8 latched without vcch cycle", 1'b0);
    otp = 1'b1;
    vcch_ok = 1'b0; idle(3); vcch_ok = 1'b1;
    idle(60);
    check_out("R8 latched while hot", 1'b0);
    otp = 1'b0;
    measure("R8 release long wait", L + 2);

    // R6 main supply loss re-arms the short wait
    vcc_ok = 1'b0;
    idle(3);
    check_out("R6 supply low", 1'b0);
    vcc_ok = 1'b1;
    measure("R6 short wait", S + 2);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule